// File: doc/BRIEF.md
# Window Scaler DDA Stepper

This block produces the source-image coordinates that a display window scaler needs for every output pixel. Software or a neighbouring controller presents the source window size and the output window size and pulses a start input. The block then derives one fixed-point step per axis. Each step is the source size times 4096, divided by the output size minus one, and the divisor is never allowed below one. Both steps are computed by a shared-timing sequential divider while a busy flag is held high.

Once the steps are ready, both axis accumulators start at zero. Each strobe on the advance input moves to the next output pixel. The horizontal accumulator gains its step on every pixel. At the end of an output line it returns to zero, and the vertical accumulator gains its own step instead. The bits above the twelve fraction bits give the source column or row, and the low twelve bits give the sub-pixel phase that a filter would use. Indices are clamped to the last source column or row. A flag marks the final pixel of the frame. The next advance after that pixel wraps the frame back to its origin.

Top module: `win_dda_stepper`

## Requirements
- R1: After a start, the block computes hstep = src_w*4096 / max(out_w-1,1) and vstep = src_h*4096 / max(out_h-1,1), both truncated. Once busy falls, step_word holds hstep in bits [SZ_W+FRAC_W-1:0] and vstep in the field above, and it does not change until the next accepted start completes.
- R2: busy rises in the cycle after a start is sampled with busy low. It stays high for exactly SZ_W+FRAC_W+1 cycles and then falls.
- R3: A start sampled while busy is high is ignored. The steps and the coordinate sequence follow the sizes of the start that was accepted.
- R4: When busy falls, src_x, src_y, phase_x and phase_y are all zero, because both accumulators begin at zero.
- R5: Within a line, each advance adds hstep to the horizontal accumulator. src_x is the accumulator shifted right by 12, and phase_x is its low 12 bits. After n advances the accumulator holds n*hstep.
- R6: An advance on the last column of a line (column max(out_w,1)-1) clears the horizontal accumulator and adds vstep to the vertical accumulator. src_y and phase_y are taken from the vertical accumulator in the same way as the horizontal outputs.
- R7: When an accumulator's integer part exceeds the source size minus one, the index reads source size minus one and the phase reads zero.
- R8: frame_end is high exactly while the current position is the last column of the last line. An advance in that state returns all four coordinate outputs to zero.
- R9: An advance while busy is high, or before any start has been accepted, leaves every output unchanged.
- R10: While reset is high, and in the cycle after it, busy, frame_end, step_word and all coordinate outputs are zero.
- R11: Outputs change only on a clock edge. A sampled advance or start shows at the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch sizes and begin step computation |
| src_w | input | SZ_W | Source window width in pixels |
| src_h | input | SZ_W | Source window height in lines |
| out_w | input | SZ_W | Output window width in pixels |
| out_h | input | SZ_W | Output window height in lines |
| adv | input | 1 | Advance to the next output pixel |
| busy | output | 1 | Step computation in progress |
| src_x | output | SZ_W | Source column for the current output pixel |
| src_y | output | SZ_W | Source row for the current output line |
| phase_x | output | FRAC_W | Horizontal sub-pixel phase |
| phase_y | output | FRAC_W | Vertical sub-pixel phase |
| frame_end | output | 1 | Current pixel is the last of the frame |
| step_word | output | 2*(SZ_W+FRAC_W) | Vertical step (high field) and horizontal step (low field) |

## Verification
A wrong quotient bit shows up in step_word in the first cycle after busy falls. The error then grows along the line, so the index or phase disagrees with the arithmetic value within the first few advances. A column or line counter that slips is seen at the first line turn: src_y moves early or late and frame_end lands on the wrong pixel. A missing clamp pushes src_x past the source width on the first downscaled pixel that overshoots. The sweep walks every output pixel of upscaled, downscaled and single-pixel windows, so each of these faults appears within one frame of the size that provokes it.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DIVIDE = 2'd1,
    PH_RUN    = 2'd2
  } dda_phase_e;

  localparam int unsigned AXIS_H = 0;
  localparam int unsigned AXIS_V = 1;
  localparam int unsigned AXIS_N = 2;

endpackage

// File: rtl/dda_divider.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per result.
module dda_divider #(
  parameter int unsigned NUM_W = 24,
  parameter int unsigned DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] work_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [DEN_W:0]   trial;
  logic             take;
  logic [DEN_W-1:0] rem_n;

  always_comb begin
    trial = {rem_q, work_q[NUM_W-1]};
    take  = (trial >= {1'b0, den_q});
    rem_n = take ? (trial[DEN_W-1:0] - den_q) : trial[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      rem_q  <= '0;
      den_q  <= DEN_W'(1);
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        work_q <= num;
        rem_q  <= '0;
        den_q  <= den;
        cnt_q  <= CNT_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= rem_n;
        work_q <= {work_q[NUM_W-2:0], take};
        cnt_q  <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = work_q;

endmodule

// File: rtl/dda_axis.sv
// One axis: fixed-point accumulator plus clamped index/phase output registers.
module dda_axis #(
  parameter int unsigned SZ_W   = 12,
  parameter int unsigned FRAC_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   step,
  input  logic [SZ_W+FRAC_W-1:0] inc,
  input  logic [SZ_W-1:0]        lim,
  output logic [SZ_W-1:0]        idx,
  output logic [FRAC_W-1:0]      phase
);

  localparam int unsigned INC_W = SZ_W + FRAC_W;
  localparam int unsigned ACC_W = INC_W + 1;
  localparam int unsigned INT_W = SZ_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_n;
  logic [INT_W-1:0] int_n;
  logic             over;

  always_comb begin
    if (clear)     acc_n = '0;
    else if (step) acc_n = acc_q + {1'b0, inc};
    else           acc_n = acc_q;
    int_n = acc_n[ACC_W-1:FRAC_W];
    over  = (int_n > {1'b0, lim});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      idx   <= '0;
      phase <= '0;
    end else begin
      acc_q <= acc_n;
      idx   <= over ? lim : int_n[SZ_W-1:0];
      phase <= over ? '0 : acc_n[FRAC_W-1:0];
    end
  end

endmodule

// File: rtl/win_dda_stepper.sv
module win_dda_stepper
  import dda_pkg::*;
#(
  parameter int unsigned SZ_W   = 12,
  parameter int unsigned FRAC_W = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [SZ_W-1:0]              src_w,
  input  logic [SZ_W-1:0]              src_h,
  input  logic [SZ_W-1:0]              out_w,
  input  logic [SZ_W-1:0]              out_h,
  input  logic                         adv,
  output logic                         busy,
  output logic [SZ_W-1:0]              src_x,
  output logic [SZ_W-1:0]              src_y,
  output logic [FRAC_W-1:0]            phase_x,
  output logic [FRAC_W-1:0]            phase_y,
  output logic                         frame_end,
  output logic [2*(SZ_W+FRAC_W)-1:0]   step_word
);

  localparam int unsigned INC_W = SZ_W + FRAC_W;

  dda_phase_e state_q, state_n;

  logic [SZ_W-1:0]   src_in  [AXIS_N];
  logic [SZ_W-1:0]   out_in  [AXIS_N];
  logic [SZ_W-1:0]   lim_q   [AXIS_N];
  logic [SZ_W-1:0]   last_q  [AXIS_N];
  logic [SZ_W-1:0]   pos_q   [AXIS_N];
  logic [SZ_W-1:0]   pos_n   [AXIS_N];
  logic [INC_W-1:0]  quot    [AXIS_N];
  logic [SZ_W-1:0]   idx     [AXIS_N];
  logic [FRAC_W-1:0] ph      [AXIS_N];
  logic [AXIS_N-1:0] div_done;
  logic [AXIS_N-1:0] clr;
  logic [AXIS_N-1:0] stp;

  logic start_go, enter_run, run_adv, h_last, v_last, fe_n;

  assign src_in[AXIS_H] = src_w;
  assign src_in[AXIS_V] = src_h;
  assign out_in[AXIS_H] = out_w;
  assign out_in[AXIS_V] = out_h;

  // Control decode: a start in the divide phase is dropped.
  always_comb begin
    start_go  = start && (state_q != PH_DIVIDE);
    enter_run = (state_q == PH_DIVIDE) && (&div_done);
    run_adv   = (state_q == PH_RUN) && adv && !start;
    h_last    = (pos_q[AXIS_H] == last_q[AXIS_H]);
    v_last    = (pos_q[AXIS_V] == last_q[AXIS_V]);

    clr[AXIS_H] = start_go || enter_run || (run_adv && h_last);
    stp[AXIS_H] = run_adv && !h_last;
    clr[AXIS_V] = start_go || enter_run || (run_adv && h_last && v_last);
    stp[AXIS_V] = run_adv && h_last && !v_last;

    state_n = state_q;
    case (state_q)
      PH_DIVIDE: if (enter_run) state_n = PH_RUN;
      default:   if (start_go)  state_n = PH_DIVIDE;
    endcase

    fe_n = (state_n == PH_RUN) &&
           (pos_n[AXIS_H] == last_q[AXIS_H]) &&
           (pos_n[AXIS_V] == last_q[AXIS_V]);
  end

  for (genvar a = 0; a < AXIS_N; a++) begin : g_axis
    logic [SZ_W-1:0] den;
    logic [SZ_W-1:0] lim_r;
    logic [SZ_W-1:0] last_r;
    logic [SZ_W-1:0] pos_r;

    // Divisor clamp: output size minus one, never below one.
    assign den = (out_in[a] > SZ_W'(1)) ? (out_in[a] - SZ_W'(1)) : SZ_W'(1);

    dda_divider #(
      .NUM_W (INC_W),
      .DEN_W (SZ_W)
    ) u_div (
      .clk    (clk),
      .rst    (rst),
      .launch (start_go),
      .num    ({src_in[a], {FRAC_W{1'b0}}}),
      .den    (den),
      .quot   (quot[a]),
      .done   (div_done[a])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lim_r  <= '0;
        last_r <= '0;
      end else if (start_go) begin
        lim_r  <= (src_in[a] == '0) ? '0 : (src_in[a] - SZ_W'(1));
        last_r <= (out_in[a] == '0) ? '0 : (out_in[a] - SZ_W'(1));
      end
    end

    assign pos_n[a] = clr[a] ? '0 : (stp[a] ? (pos_r + SZ_W'(1)) : pos_r);

    always_ff @(posedge clk) begin
      if (rst) pos_r <= '0;
      else     pos_r <= pos_n[a];
    end

    assign lim_q[a]  = lim_r;
    assign last_q[a] = last_r;
    assign pos_q[a]  = pos_r;

    dda_axis #(
      .SZ_W   (SZ_W),
      .FRAC_W (FRAC_W)
    ) u_axis (
      .clk   (clk),
      .rst   (rst),
      .clear (clr[a]),
      .step  (stp[a]),
      .inc   (step_word[a*INC_W +: INC_W]),
      .lim   (lim_q[a]),
      .idx   (idx[a]),
      .phase (ph[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_IDLE;
      busy      <= 1'b0;
      frame_end <= 1'b0;
      step_word <= '0;
    end else begin
      state_q   <= state_n;
      busy      <= (state_n == PH_DIVIDE);
      frame_end <= fe_n;
      if (enter_run) step_word <= {quot[AXIS_V], quot[AXIS_H]};
    end
  end

  assign src_x   = idx[AXIS_H];
  assign src_y   = idx[AXIS_V];
  assign phase_x = ph[AXIS_H];
  assign phase_y = ph[AXIS_V];

endmodule

// File: rtl/dda_stepper_chk.sv
module dda_stepper_chk #(
  parameter int unsigned SZ_W   = 12,
  parameter int unsigned FRAC_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic                       adv,
  input logic                       busy,
  input logic                       frame_end,
  input logic [SZ_W-1:0]            src_x,
  input logic [SZ_W-1:0]            src_y,
  input logic [FRAC_W-1:0]          phase_x,
  input logic [FRAC_W-1:0]          phase_y,
  input logic [2*(SZ_W+FRAC_W)-1:0] step_word,
  input logic [SZ_W-1:0]            lim_x,
  input logic [SZ_W-1:0]            lim_y
);

  localparam int unsigned INC_W = SZ_W + FRAC_W;
  localparam int unsigned BC_W  = $clog2(INC_W + 3);

  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + BC_W'(1);
    else           busy_cnt <= '0;
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == BC_W'(INC_W + 1)));

  p_step_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(step_word));

  p_origin_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (src_x == '0 && src_y == '0 && phase_x == '0 && phase_y == '0));

  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      ($stable(src_x) && $stable(src_y) && $stable(phase_x) && $stable(phase_y)));

  p_index_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (src_x <= lim_x) && (src_y <= lim_y));

  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_end && adv) |=>
      (src_x == '0 && src_y == '0 && phase_x == '0 && phase_y == '0));

endmodule

bind win_dda_stepper dda_stepper_chk #(
  .SZ_W   (SZ_W),
  .FRAC_W (FRAC_W)
) u_dda_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .adv       (adv),
  .busy      (busy),
  .frame_end (frame_end),
  .src_x     (src_x),
  .src_y     (src_y),
  .phase_x   (phase_x),
  .phase_y   (phase_y),
  .step_word (step_word),
  .lim_x     (lim_q[0]),
  .lim_y     (lim_q[1])
);

// File: tb/test_win_dda_stepper.sv
module test_win_dda_stepper;

  localparam int SZ    = 5;
  localparam int FR    = 12;
  localparam int INC_W = SZ + FR;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [SZ-1:0]     src_w = '0, src_h = '0, out_w = '0, out_h = '0;
  logic              adv = 1'b0;
  logic              busy, frame_end;
  logic [SZ-1:0]     src_x, src_y;
  logic [FR-1:0]     phase_x, phase_y;
  logic [2*INC_W-1:0] step_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  win_dda_stepper #(.SZ_W(SZ), .FRAC_W(FR)) i_win_dda_stepper (
    .clk(clk), .rst(rst), .start(start),
    .src_w(src_w), .src_h(src_h), .out_w(out_w), .out_h(out_h),
    .adv(adv), .busy(busy),
    .src_x(src_x), .src_y(src_y), .phase_x(phase_x), .phase_y(phase_y),
    .frame_end(frame_end), .step_word(step_word)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ex_step(input int src, input int outsz);
    return (src * 4096) / ((outsz > 1) ? outsz - 1 : 1);
  endfunction

  function automatic int ex_idx(input int src, input int inc, input int n);
    int ii = (n * inc) >>> 12;
    return (ii > src - 1) ? src - 1 : ii;
  endfunction

  function automatic int ex_ph(input int src, input int inc, input int n);
    int acc = n * inc;
    return ((acc >>> 12) > src - 1) ? 0 : (acc & 4095);
  endfunction

  task automatic check_origin(input string req);
    chk(src_x == 0 && src_y == 0 && phase_x == 0 && phase_y == 0, req,
        longint'({src_x, src_y, phase_x, phase_y}), 0);
  endtask

  task automatic run_cfg(input int sw, input int sh, input int ow, input int oh,
                         input bit poke, input bit gaps);
    int n = 0;
    int hs = ex_step(sw, ow);
    int vs = ex_step(sh, oh);
    @(negedge clk);
    src_w = SZ'(sw); src_h = SZ'(sh); out_w = SZ'(ow); out_h = SZ'(oh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (poke && n == 3) begin
        start = 1'b1; adv = 1'b1;
        src_w = SZ'(7); src_h = SZ'(9); out_w = SZ'(3); out_h = SZ'(4);
      end else begin
        start = 1'b0; adv = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; adv = 1'b0;
    chk(n == INC_W + 1, "R2", n, INC_W + 1);
    chk(step_word == {INC_W'(vs), INC_W'(hs)}, poke ? "R3" : "R1",
        longint'(step_word), longint'({INC_W'(vs), INC_W'(hs)}));
    check_origin(poke ? "R9" : "R4");
    for (int j = 0; j < oh; j++) begin
      for (int i = 0; i < ow; i++) begin
        chk(src_x == SZ'(ex_idx(sw, hs, i)), (ex_idx(sw, hs, i) == sw - 1) ? "R7" : "R5",
            src_x, ex_idx(sw, hs, i));
        chk(phase_x == FR'(ex_ph(sw, hs, i)), "R5", phase_x, ex_ph(sw, hs, i));
        chk(src_y == SZ'(ex_idx(sh, vs, j)), "R6", src_y, ex_idx(sh, vs, j));
        chk(phase_y == FR'(ex_ph(sh, vs, j)), "R6", phase_y, ex_ph(sh, vs, j));
        chk(frame_end == (i == ow - 1 && j == oh - 1), "R8", frame_end,
            (i == ow - 1 && j == oh - 1));
        if (gaps && ((i + j) % 3 == 0)) @(negedge clk);  // idle cycle, R11
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
      end
    end
    check_origin("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sv[4];
    int ov[4];
    sv = '{1, 3, 8, 31};
    ov = '{1, 2, 5, 16};
    repeat (3) @(negedge clk);
    chk(!busy && !frame_end && step_word == 0, "R10", longint'({busy, frame_end}), 0);
    check_origin("R10");
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && step_word == 0, "R10", busy, 0);
    // Advances before any start: R9
    adv = 1'b1;
    repeat (3) @(negedge clk);
    adv = 1'b0;
    check_origin("R9");
    chk(!busy && !frame_end, "R9", longint'({busy, frame_end}), 0);
    for (int k = 0; k < 16; k++) begin
      run_cfg(sv[k % 4], sv[(k / 4 + k) % 4], ov[k / 4], ov[(k + 3) % 4],
              k == 5, (k % 2) == 1);
    end
    // Clamp case: a single output column uses a divisor of one (R1)
    run_cfg(31, 8, 1, 16, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule